// File: doc/BRIEF.md
# Programmable Input Deglitch Filter

This block cleans up a bus of digital input pins before the rest of the chip sees them. Each raw pin first passes through a two-flop synchronizer. A channel whose filter is switched on then holds its previous filtered level until the synchronized pin has disagreed with it for a programmed number of 200 ns ticks. Only then does the new level pass. A channel whose filter is off follows the synchronized pin with no added hold time.

Pins are grouped into ports of `PORT_W` channels. Each port has its own enable register with one bit per channel. A single interval register, counted in ticks, applies to every enabled channel on every port. A prescaler divides the system clock into a one-cycle tick every `CLKS_PER_TICK` clocks. The default of 40 suits a 200 MHz clock.

The raw inputs are sampled as levels on every clock. The filtered outputs are levels valid on every clock. Neither side has a valid/ready handshake, so there is no back-pressure. Software programs the block through a simple single-cycle write strobe.

Top module: `deglitch_filter`

## Requirements
- R1: After reset, `filt_out` is all zeros, every channel enable is cleared and the interval is 0, so all channels start in pass-through.
- R2: A channel whose enable bit is 0 drives `filt_out` equal to its `raw_in` value from 3 clocks earlier: two synchronizer stages, then one output register.
- R3: A write to address 0x08 loads the interval from `reg_wdata[19:0]`, so the largest interval is 0xFFFFF ticks. Bits 31:20 of the written word are ignored.
- R4: A write to address 0x44 + 0x10*p loads the enable mask of port p from `reg_wdata[PORT_W-1:0]`. Bit b of that mask enables channel p*PORT_W + b.
- R5: Take an enabled channel with interval N > 0 and tick period P clocks. A raw level held for at most (N-1)*P clocks before the pin returns never reaches `filt_out`. A raw level held steady for N*P clocks or more reaches `filt_out` no later than N*P + 3 clocks after the raw change.
- R6: An enabled channel with interval 0 behaves exactly as in R2.
- R7: The one interval value governs the enabled channels of every port at once.
- R8: Every write to the interval register restarts the stability count of every channel. An enabled channel does not change in the cycle that follows the write, and it then needs a full new stability period before it can change.
- R9: The tick occurs once every `CLKS_PER_TICK` clocks. An enabled channel with a non-zero interval changes only on a tick edge.
- R10: Any change of a `filt_out` bit is always to the current synchronized value of that bit's pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| raw_in | input | NPORTS*PORT_W | Unsynchronized input pins |
| filt_out | output | NPORTS*PORT_W | Filtered input levels |

## Verification
The filter is driven with three kinds of input pattern:
- Plain steps show that a sustained level is accepted within the stated bound.
- Short glitches, both towards a level and away from it, show that brief disagreements are rejected. The output is watched on every cycle, so a glitch that slips through and later recovers is still caught.
- A long pulse followed by a quick return tells acceptance apart from simple delay.

Ports with mixed enable masks show that the enable is per bit and that the single interval serves every port. An interval rewrite in mid-count tells a restarting counter apart from one that keeps its progress. The bench runs with a 4-clock tick.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int IVL_W       = 20;
  localparam logic [ADDR_W-1:0] IVL_ADDR    = 8'h08;
  localparam logic [ADDR_W-1:0] PORT_BASE   = 8'h40;
  localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h10;
  localparam logic [ADDR_W-1:0] ENA_OFFSET  = 8'h04;

  // Byte address of the enable mask for a given port.
  function automatic logic [ADDR_W-1:0] ena_addr(input int port);
    return PORT_BASE + ADDR_W'(port) * PORT_STRIDE + ENA_OFFSET;
  endfunction
endpackage

// File: rtl/dgf_tick.sv
module dgf_tick #(
  parameter int CLKS_PER_TICK = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      logic unused_rst;
      assign unused_rst = rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLKS_PER_TICK);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
  import dgf_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PORT_W = 8,
  localparam int NCH = NPORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [IVL_W-1:0]  ivl,
  output logic [NCH-1:0]    en_mask,
  output logic              restart
);
  logic ivl_hit;
  logic [DATA_W-1:IVL_W] unused_wdata_hi;

  assign ivl_hit = reg_wr && (reg_addr == IVL_ADDR);
  assign unused_wdata_hi = reg_wdata[DATA_W-1:IVL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl     <= '0;
      restart <= 1'b0;
    end else begin
      restart <= ivl_hit;
      if (ivl_hit) ivl <= reg_wdata[IVL_W-1:0];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n)
        en_mask[p*PORT_W +: PORT_W] <= '0;
      else if (reg_wr && (reg_addr == ena_addr(p)))
        en_mask[p*PORT_W +: PORT_W] <= reg_wdata[PORT_W-1:0];
    end
  end
endmodule

// File: rtl/dgf_chan.sv
module dgf_chan
  import dgf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl,
  input  logic             ivl_zero,
  input  logic             tick,
  input  logic             restart,
  output logic             dout
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      cnt_q <= '0;
    end else if (!en || ivl_zero) begin
      dout  <= din;
      cnt_q <= '0;
    end else if (restart || (din == dout)) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, ivl}) begin
        dout  <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc[IVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/deglitch_filter.sv
module deglitch_filter
  import dgf_pkg::*;
#(
  parameter int NPORTS        = 4,
  parameter int PORT_W        = 8,
  parameter int CLKS_PER_TICK = 40,
  localparam int NCH = NPORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCH-1:0]    raw_in,
  output logic [NCH-1:0]    filt_out
);
  logic [NCH-1:0]   sync1_q;
  logic [NCH-1:0]   sync_q;
  logic [IVL_W-1:0] ivl_q;
  logic [NCH-1:0]   en_mask;
  logic             restart;
  logic             tick;
  logic             ivl_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync_q  <= '0;
    end else begin
      sync1_q <= raw_in;
      sync_q  <= sync1_q;
    end
  end

  dgf_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  dgf_regs #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ivl      (ivl_q),
    .en_mask  (en_mask),
    .restart  (restart)
  );

  assign ivl_zero = (ivl_q == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dgf_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (sync_q[c]),
      .en      (en_mask[c]),
      .ivl     (ivl_q),
      .ivl_zero(ivl_zero),
      .tick    (tick),
      .restart (restart),
      .dout    (filt_out[c])
    );
  end
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker #(
  parameter int NCH           = 32,
  parameter int CLKS_PER_TICK = 40,
  parameter int IVL_W         = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             restart,
  input logic [NCH-1:0]   sync_in,
  input logic [NCH-1:0]   en,
  input logic [IVL_W-1:0] ivl,
  input logic [NCH-1:0]   out
);
  logic [NCH-1:0] en_f;
  assign en_f = en & {NCH{ivl != '0}};

  localparam int TW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  logic [TW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || tick) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  // R9: ticks arrive exactly CLKS_PER_TICK clocks apart
  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (32'(gap_q) == 32'(CLKS_PER_TICK - 1)));

  // R9: filtered channels move only on tick edges
  assert_change_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((out ^ $past(out)) & $past(en_f) & ~{NCH{$past(tick)}}) == '0);

  // R2 / R6: unfiltered channels track the synchronizer one clock later
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out ^ $past(sync_in)) & ~$past(en_f)) == '0);

  // R10: a changed output bit takes the synchronized pin value
  assert_change_to_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((out ^ $past(out)) & (out ^ $past(sync_in))) == '0);

  // R8: no filtered channel moves on the edge that applies a restart
  assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (((out ^ $past(out)) & $past(en_f)) == '0));
endmodule

bind deglitch_filter dgf_checker #(
  .NCH          (NCH),
  .CLKS_PER_TICK(CLKS_PER_TICK),
  .IVL_W        (dgf_pkg::IVL_W)
) u_dgf_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .restart(restart),
  .sync_in(sync_q),
  .en     (en_mask),
  .ivl    (ivl_q),
  .out    (filt_out)
);

// File: tb/test_deglitch_filter.sv
module test_deglitch_filter;
  localparam int NPORTS = 4;
  localparam int PORT_W = 8;
  localparam int P      = 4;
  localparam int NCH    = NPORTS * PORT_W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [NCH-1:0] raw_in = '0;
  logic [NCH-1:0] filt_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  deglitch_filter #(.NPORTS(NPORTS), .PORT_W(PORT_W), .CLKS_PER_TICK(P)) i_deglitch_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .raw_in(raw_in), .filt_out(filt_out)
  );

  // Vector: glitch value, glitch length, base value, settle clocks, expected byte.
  typedef struct packed {
    logic [7:0] gval;
    logic [7:0] glen;
    logic [7:0] base;
    logic [7:0] settle;
    logic [7:0] expv;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{8'h3C, 8'd0,  8'h3C, 8'd14, 8'h3C},
    '{8'hFF, 8'd4,  8'h3C, 8'd14, 8'h3C},
    '{8'h00, 8'd2,  8'h3C, 8'd14, 8'h3C},
    '{8'hC3, 8'd0,  8'hC3, 8'd14, 8'hC3},
    '{8'h00, 8'd20, 8'hC3, 8'd2,  8'h00},
    '{8'hC3, 8'd0,  8'hC3, 8'd14, 8'hC3},
    '{8'h5A, 8'd1,  8'hC3, 8'd14, 8'hC3},
    '{8'h00, 8'd0,  8'h00, 8'd14, 8'h00}
  };

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", wd);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] prev;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 reset output", filt_out, '0);

    // R1/R2: enables clear after reset, so channels pass through with 3-clock latency
    raw_in = 32'hDEADBEEF;
    wait_cyc(2);
    chk("R2 not before 3 clocks", filt_out, '0);
    wait_cyc(1);
    chk("R1 R2 pass-through after reset", filt_out, 32'hDEADBEEF);
    raw_in = '0;
    wait_cyc(5);

    // R6: enabled with interval 0 is still pass-through
    wr(8'h44, 32'h000000FF);
    raw_in[7:0] = 8'h55;
    wait_cyc(3);
    chk("R6 interval zero pass-through", filt_out, 32'h00000055);
    raw_in[7:0] = 8'h00;
    wait_cyc(3);

    // R3: upper bits ignored, effective interval 2
    wr(8'h08, 32'hFFF00002);

    // R5 table walk on port 0; the output is watched every cycle
    prev = 8'h00;
    for (int i = 0; i < NV; i++) begin
      int bad = 0;
      int tot;
      tot = int'(VT[i].glen) + int'(VT[i].settle);
      for (int c = 0; c < tot; c++) begin
        raw_in[7:0] = (c < int'(VT[i].glen)) ? VT[i].gval : VT[i].base;
        @(negedge clk);
        if (filt_out[7:0] !== prev && filt_out[7:0] !== VT[i].expv) bad++;
      end
      checks++;
      if (bad != 0 || filt_out[7:0] !== VT[i].expv) begin
        failures++;
        $display("FAIL R5 R3 vector %0d actual=%h expected=%h stray=%0d",
                 i, filt_out[7:0], VT[i].expv, bad);
      end
      prev = VT[i].expv;
    end

    // R4/R7: port 3 enables only its low nibble; shared interval 2 applies
    wr(8'h74, 32'h0000000F);
    raw_in[31:24] = 8'hFF;
    wait_cyc(3);
    chk("R4 per-bit enable on port 3", filt_out, 32'hF0000000);
    raw_in[31:24] = 8'h00;
    wait_cyc(15);
    chk("R7 shared interval rejects glitch on port 3", filt_out, '0);

    // R8: interval rewrite restarts counting on port 2
    wr(8'h64, 32'h000000FF);
    wr(8'h08, 32'h00000003);
    wait_cyc(20);
    raw_in[23:16] = 8'hFF;
    wait_cyc(7);
    wr(8'h08, 32'h00000003);
    wait_cyc(6);
    chk("R8 restart delays acceptance", filt_out, '0);
    wait_cyc(20);
    chk("R8 accepted after fresh period", filt_out, 32'h00FF0000);

    done = 1'b1;
    finish_run();
  end
endmodule